// File: doc/BRIEF.md
# Reset Hold Sequencer

This block keeps a processor core in reset for a timed interval after every reset event. The interval is measured in ticks of a slow, free-running on-chip clock that keeps running while the main oscillator is stopped. The whole block runs on that slow clock. The hold length depends on two things. The first is the oscillator mode code. The second is whether the pending interval is the first one after power-up or a later one.

Crystal and resonator modes always wait the long interval, so that the oscillation has time to settle. The remaining modes wait a medium interval after power-up and only a short one on later resets. The external reset pin holds the core for as long as it is low, and the interval starts once the pin reads high. A watchdog time-out from sleep, a pin-change wake or a comparator-change wake starts the interval again. A cause output records the source of the most recent reset, so it can be read once the core is running.

Top module: `reset_hold_seq`

## Requirements
- R1: While `porActive` is high, `coreReset` is 1 at once, without waiting for a clock edge, and `resetCause` reads 1 (power-on).
- R2: While `mclrLevel` is low, `coreReset` stays 1. A falling pin outside a hold sets `resetCause` to 2 (external pin).
- R3: For oscillator modes 0, 1 and 2 (crystal/resonator), the hold lasts LONG_TICKS clock edges, both after power-up and on later resets.
- R4: For oscillator modes 3 to 7, the hold lasts MID_TICKS edges for the first interval after power-up and SHORT_TICKS edges for any later one.
- R5: `coreReset` falls exactly N rising edges after the edge that samples the start condition. The start condition is a wake pulse, or the pin reading high after a hold (including the first edge after power-on release). N is the hold length.
- R6: A `wdtSleepWake` pulse re-asserts `coreReset` on the edge that samples it, starts a fresh hold and sets `resetCause` to 3.
- R7: A `pinWake` pulse gives `resetCause` 4 and a `cmpWake` pulse gives 5, each with a fresh hold.
- R8: A wake event that arrives while a hold is counting restarts the count from zero.
- R9: When several sources fire on the same edge, the precedence is pin low, then watchdog, then pin-change, then comparator.
- R10: Wake pulses that arrive while the pin is low have no effect on `resetCause` or on the hold.
- R11: While the core runs and no event arrives, `resetCause` does not change and `coreReset` stays 0.
- R12: The first-interval status ends only when a hold completes. A pin reset during the power-up hold therefore still gets MID_TICKS in modes 3 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running slow clock that times the hold |
| porActive | input | 1 | Power-on indication, active high, asynchronous |
| mclrLevel | input | 1 | External reset pin level, low holds reset |
| wdtSleepWake | input | 1 | Watchdog time-out during sleep, one-cycle pulse |
| pinWake | input | 1 | Wake on pin change, one-cycle pulse |
| cmpWake | input | 1 | Wake on comparator change, one-cycle pulse |
| oscMode | input | 3 | Oscillator mode code, 0-2 crystal/resonator, 3-7 others |
| coreReset | output | 1 | Held reset to the processor core, active high |
| resetCause | output | 3 | Last reset source: 1 power-on, 2 pin, 3 watchdog, 4 pin-change, 5 comparator |

## Verification
Power-on release is timed in a non-crystal mode and compared with the following wake, which tells the medium hold apart from the short one. Crystal modes are timed after both kinds of reset to show that the interval does not shrink. A second wake is fired partway through a long hold, which separates a restarting counter from one that merely continues. Simultaneous pulses, wake pulses during a low pin, and a pin reset inside the power-up hold check precedence, masking and the first-interval flag. Seeded random mode and source sequences then cover the mode-by-source combinations.

// File: rtl/rhsPkg.sv
package rhsPkg;

  localparam int CAUSE_W = 3;
  localparam int MODE_W  = 3;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_POR  = 3'd1,
    CAUSE_PIN  = 3'd2,
    CAUSE_WDT  = 3'd3,
    CAUSE_PCHG = 3'd4,
    CAUSE_CMP  = 3'd5
  } cause_e;

  typedef enum logic [1:0] {
    ST_HOLD   = 2'd0,
    ST_TIMING = 2'd1,
    ST_RUN    = 2'd2
  } holdState_e;

  // Strobes from control to the tick counter
  typedef struct packed {
    logic clear;
    logic advance;
  } rhsStrobe_t;

endpackage

// File: rtl/rhs_timer.sv
module rhs_timer
  import rhsPkg::*;
#(
  parameter int LONG_TICKS   = 1152,
  parameter int MID_TICKS    = 72,
  parameter int SHORT_TICKS  = 1,
  parameter int CNT_W        = 11,
  parameter logic [7:0] CRYSTAL_MASK = 8'b0000_0111
) (
  input  logic              clk,
  input  logic              porActive,
  input  rhsStrobe_t        strobe,
  input  logic [MODE_W-1:0] oscMode,
  input  logic              firstPowerUp,
  output logic              done
);

  localparam logic [CNT_W-1:0] LONG_L  = CNT_W'(LONG_TICKS);
  localparam logic [CNT_W-1:0] MID_L   = CNT_W'(MID_TICKS);
  localparam logic [CNT_W-1:0] SHORT_L = CNT_W'(SHORT_TICKS);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] limit;
  logic             isCrystal;

  // Per-mode lookup into the crystal mask
  logic [(1<<MODE_W)-1:0] crystalVec;
  for (genvar m = 0; m < (1 << MODE_W); m++) begin : g_modeMask
    assign crystalVec[m] = CRYSTAL_MASK[m];
  end

  assign isCrystal = crystalVec[oscMode];

  always_comb begin
    if (isCrystal)         limit = LONG_L;
    else if (firstPowerUp) limit = MID_L;
    else                   limit = SHORT_L;
  end

  always_ff @(posedge clk or posedge porActive) begin
    if (porActive)          count <= '0;
    else if (strobe.clear)  count <= '0;
    else if (strobe.advance) count <= count + CNT_W'(1);
  end

  // The comparison tolerates a mode change mid-hold
  assign done = (count >= (limit - CNT_W'(1)));

  assert_restart_zero_R8: assert property (@(posedge clk) disable iff (porActive)
    strobe.clear |=> (count == '0))
    else $error("count not restarted after clear");

endmodule

// File: rtl/rhs_ctrl.sv
module rhs_ctrl
  import rhsPkg::*;
(
  input  logic               clk,
  input  logic               porActive,
  input  logic               mclrLevel,
  input  logic               wdtSleepWake,
  input  logic               pinWake,
  input  logic               cmpWake,
  input  logic               done,
  output rhsStrobe_t         strobe,
  output logic               firstPowerUp,
  output logic               coreReset,
  output logic [CAUSE_W-1:0] resetCause
);

  holdState_e stateQ, stateD;
  cause_e     causeQ, causeD;
  logic       firstQ, firstD;
  logic       anyWake;

  assign anyWake = wdtSleepWake | pinWake | cmpWake;

  always_comb begin
    stateD = stateQ;
    causeD = causeQ;
    firstD = firstQ;
    strobe = '0;
    if (!mclrLevel) begin
      stateD       = ST_HOLD;
      strobe.clear = 1'b1;
      if (stateQ != ST_HOLD) causeD = CAUSE_PIN;
    end else if (stateQ == ST_HOLD) begin
      stateD       = ST_TIMING;
      strobe.clear = 1'b1;
    end else if (anyWake) begin
      stateD       = ST_TIMING;
      strobe.clear = 1'b1;
      if (wdtSleepWake)  causeD = CAUSE_WDT;
      else if (pinWake)  causeD = CAUSE_PCHG;
      else               causeD = CAUSE_CMP;
    end else if (stateQ == ST_TIMING) begin
      if (done) begin
        stateD       = ST_RUN;
        strobe.clear = 1'b1;
        firstD       = 1'b0;
      end else begin
        strobe.advance = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or posedge porActive) begin
    if (porActive) begin
      stateQ <= ST_HOLD;
      causeQ <= CAUSE_POR;
      firstQ <= 1'b1;
    end else begin
      stateQ <= stateD;
      causeQ <= causeD;
      firstQ <= firstD;
    end
  end

  assign coreReset    = (stateQ != ST_RUN);
  assign firstPowerUp = firstQ;
  assign resetCause   = causeQ;

  assert_pin_hold_R2: assert property (@(posedge clk) disable iff (porActive)
    !mclrLevel |=> coreReset)
    else $error("core released while pin low");

  assert_wdt_rearm_R6: assert property (@(posedge clk) disable iff (porActive)
    (stateQ != ST_HOLD && mclrLevel && wdtSleepWake) |=> (coreReset && resetCause == CAUSE_WDT))
    else $error("watchdog wake did not rearm");

  assert_release_on_done_R5: assert property (@(posedge clk) disable iff (porActive)
    $fell(coreReset) |-> $past(done))
    else $error("release without completed count");

  assert_cause_stable_R11: assert property (@(posedge clk) disable iff (porActive)
    (!coreReset && $past(!coreReset)) |-> $stable(resetCause))
    else $error("cause changed while running");

endmodule

// File: rtl/reset_hold_seq.sv
module reset_hold_seq
  import rhsPkg::*;
#(
  parameter int LONG_TICKS  = 1152,
  parameter int MID_TICKS   = 72,
  parameter int SHORT_TICKS = 1,
  parameter logic [7:0] CRYSTAL_MASK = 8'b0000_0111
) (
  input  logic       clk,
  input  logic       porActive,
  input  logic       mclrLevel,
  input  logic       wdtSleepWake,
  input  logic       pinWake,
  input  logic       cmpWake,
  input  logic [2:0] oscMode,
  output logic       coreReset,
  output logic [2:0] resetCause
);

  localparam int MAX_A     = (LONG_TICKS > MID_TICKS) ? LONG_TICKS : MID_TICKS;
  localparam int MAX_TICKS = (MAX_A > SHORT_TICKS) ? MAX_A : SHORT_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  rhsStrobe_t strobe;
  logic       done;
  logic       firstPowerUp;

  rhs_ctrl u_ctrl (
    .clk          (clk),
    .porActive    (porActive),
    .mclrLevel    (mclrLevel),
    .wdtSleepWake (wdtSleepWake),
    .pinWake      (pinWake),
    .cmpWake      (cmpWake),
    .done         (done),
    .strobe       (strobe),
    .firstPowerUp (firstPowerUp),
    .coreReset    (coreReset),
    .resetCause   (resetCause)
  );

  rhs_timer #(
    .LONG_TICKS   (LONG_TICKS),
    .MID_TICKS    (MID_TICKS),
    .SHORT_TICKS  (SHORT_TICKS),
    .CNT_W        (CNT_W),
    .CRYSTAL_MASK (CRYSTAL_MASK)
  ) u_timer (
    .clk          (clk),
    .porActive    (porActive),
    .strobe       (strobe),
    .oscMode      (oscMode),
    .firstPowerUp (firstPowerUp),
    .done         (done)
  );

endmodule

// File: tb/test_reset_hold_seq.sv
module test_reset_hold_seq;

  localparam int LONG_T  = 1152;
  localparam int MID_T   = 72;
  localparam int SHORT_T = 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       porActive, mclrLevel, wdtSleepWake, pinWake, cmpWake;
  logic [2:0] oscMode;
  logic       coreReset;
  logic [2:0] resetCause;

  int  checks = 0;
  int  errors = 0;
  bit  firstModel;

  reset_hold_seq #(
    .LONG_TICKS  (LONG_T),
    .MID_TICKS   (MID_T),
    .SHORT_TICKS (SHORT_T)
  ) i_reset_hold_seq (
    .clk          (clk),
    .porActive    (porActive),
    .mclrLevel    (mclrLevel),
    .wdtSleepWake (wdtSleepWake),
    .pinWake      (pinWake),
    .cmpWake      (cmpWake),
    .oscMode      (oscMode),
    .coreReset    (coreReset),
    .resetCause   (resetCause)
  );

  function automatic int expDelay(int mode, bit first);
    if (mode <= 2) return LONG_T;
    return first ? MID_T : SHORT_T;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts negedges after the start edge until coreReset drops
  task automatic measure(output int k);
    k = 0;
    while (coreReset && k < LONG_T + 20) begin
      @(negedge clk);
      k++;
    end
  endtask

  // kind: 0 pin low, 1 watchdog, 2 pin-change, 3 comparator
  task automatic fireAndTime(int kind, int lowCycles, string req);
    int k, exp;
    @(negedge clk);
    if (kind == 0) begin
      mclrLevel = 1'b0;
      repeat (lowCycles) @(negedge clk);
      chk({req, " R2 held while pin low"}, coreReset, 1);
      mclrLevel = 1'b1;
    end else begin
      wdtSleepWake = (kind == 1);
      pinWake      = (kind == 2);
      cmpWake      = (kind == 3);
    end
    @(posedge clk);
    @(negedge clk);
    wdtSleepWake = 1'b0; pinWake = 1'b0; cmpWake = 1'b0;
    chk({req, " R6 reset asserted after event"}, coreReset, 1);
    exp = expDelay(oscMode, firstModel);
    measure(k);
    chk({req, " R5 hold length"}, k, exp);
    chk({req, " R7 cause code"}, resetCause, kind + 2);
    firstModel = 1'b0;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL R5 watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k, j;
    logic [2:0] causeSnap;
    void'($urandom(32'h5eed_1234));
    porActive = 1'b1; mclrLevel = 1'b1; oscMode = 3'd3;
    wdtSleepWake = 1'b0; pinWake = 1'b0; cmpWake = 1'b0;
    firstModel = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset during power-on", coreReset, 1);
    chk("R1 cause power-on", resetCause, 1);

    // Power-up hold in a non-crystal mode: medium interval
    porActive = 1'b0;
    @(posedge clk); @(negedge clk);
    measure(k);
    chk("R4 power-up medium hold", k, MID_T);
    chk("R1 cause after power-on release", resetCause, 1);
    firstModel = 1'b0;

    // Later reset in the same mode: short interval
    fireAndTime(1, 0, "R4 short after watchdog");
    oscMode = 3'd0;
    fireAndTime(1, 0, "R3 crystal LP watchdog");
    oscMode = 3'd2;
    fireAndTime(2, 0, "R3 crystal HS pin-change");

    // R11: idle running, nothing changes
    causeSnap = resetCause;
    repeat (40) @(negedge clk);
    chk("R11 still running", coreReset, 0);
    chk("R11 cause stable", resetCause, causeSnap);

    // R8: restart mid-hold
    oscMode = 3'd1;
    @(negedge clk); wdtSleepWake = 1'b1;
    @(negedge clk); wdtSleepWake = 1'b0;
    repeat (300) @(negedge clk);
    chk("R8 still held mid-count", coreReset, 1);
    cmpWake = 1'b1;
    @(posedge clk); @(negedge clk); cmpWake = 1'b0;
    measure(k);
    chk("R8 count restarted", k, LONG_T);
    chk("R8 cause comparator", resetCause, 5);

    // R9: precedence among simultaneous sources
    oscMode = 3'd4;
    @(negedge clk); wdtSleepWake = 1'b1; pinWake = 1'b1; cmpWake = 1'b1;
    @(posedge clk); @(negedge clk); wdtSleepWake = 1'b0; pinWake = 1'b0; cmpWake = 1'b0;
    measure(k);
    chk("R9 watchdog wins", resetCause, 3);
    chk("R9 short hold", k, SHORT_T);
    @(negedge clk); pinWake = 1'b1; cmpWake = 1'b1;
    @(posedge clk); @(negedge clk); pinWake = 1'b0; cmpWake = 1'b0;
    measure(k);
    chk("R9 pin-change over comparator", resetCause, 4);
    @(negedge clk); mclrLevel = 1'b0; wdtSleepWake = 1'b1;
    @(negedge clk); wdtSleepWake = 1'b0;
    chk("R9 pin low wins", resetCause, 2);

    // R10: wake pulses while pin low are ignored
    repeat (3) @(negedge clk);
    wdtSleepWake = 1'b1; cmpWake = 1'b1;
    @(negedge clk); wdtSleepWake = 1'b0; cmpWake = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 cause unchanged", resetCause, 2);
    chk("R10 still held", coreReset, 1);
    mclrLevel = 1'b1;
    @(posedge clk); @(negedge clk);
    measure(k);
    chk("R10 hold after pin release", k, SHORT_T);

    // R1: power-on asserts reset without a clock edge
    #3;
    porActive = 1'b1;
    #1;
    chk("R1 immediate reset", coreReset, 1);
    chk("R1 cause reloaded", resetCause, 1);

    // R12: pin reset inside power-up hold keeps the medium interval
    oscMode = 3'd5;
    firstModel = 1'b1;
    @(negedge clk); porActive = 1'b0;
    repeat (10) @(negedge clk);
    chk("R12 inside power-up hold", coreReset, 1);
    fireAndTime(0, 4, "R12 pin during power-up");
    fireAndTime(1, 0, "R12 later short");

    // Seeded random mode and source sequences
    for (int i = 0; i < 30; i++) begin
      oscMode = 3'($urandom_range(0, 7));
      j = $urandom_range(0, 3);
      fireAndTime(j, $urandom_range(1, 5), "R3 R4 random");
      repeat ($urandom_range(0, 4)) @(negedge clk);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule